// File: doc/BRIEF.md
# Pointer Register and Auxiliary Pointer File

This block keeps a 16-bit pointer register together with a file of sixteen 16-bit auxiliary pointers. A sequencer uses the auxiliary file to park and restore pointer values in a single cycle, so it does not have to save them through main memory. Each transfer or swap into the file can also adjust the stored copy by one or two. This makes it cheap to step a nibble-addressed pointer through memory.

The pointer can also be handled as four 4-bit fields. A nibble produced by an ALU can be written into any field. A separate step request moves only the lowest field up or down by one, wrapping within the nibble. Any operation that reads the pointer for a transfer sees the value it had at the start of the cycle. All updates become visible on the pointer output one clock edge after the request.

Top module: `ptr_aux_unit`

## Requirements
- R1: A synchronous active-high reset clears the pointer and all sixteen auxiliary entries to zero.
- R2: Operation code 1 (load) copies the auxiliary entry selected by the index into the pointer on the next edge.
- R3: Operation codes 2, 3, 4, 5 and 6 (save) write the pointer plus 0, +1, -1, +2 or -2 respectively into the selected auxiliary entry, and leave the pointer unchanged.
- R4: Operation codes 7, 8, 9, 10 and 11 (swap) load the old selected entry into the pointer and write the old pointer plus 0, +1, -1, +2 or -2 respectively into that entry.
- R5: The adjustment added to the auxiliary copy wraps modulo 65536.
- R6: With the field write enable set, field select 0, 1, 2 or 3 replaces pointer bits 3:0, 7:4, 11:8 or 15:12 respectively with the write data.
- R7: Step code 1 increments and step code 2 decrements the lowest field modulo 16 without carry or borrow into bits 15:4. Step codes 0 and 3 do nothing.
- R8: When a field write and a step occur in the same cycle, a write to field 0 wins over the step. A write to any other field is applied together with the step.
- R9: A load or swap in the same cycle as a field write or step takes the auxiliary value, and the field write and step are dropped.
- R10: Operation codes 0 and 12 to 15 leave the pointer and all auxiliary entries unchanged, whatever the index.
- R11: The nibble read port returns pointer field 0 to 3, chosen by the read select, combinationally from the current pointer.
- R12: A swap with -2 followed by a plain swap on the same entry leaves that entry unchanged and leaves the pointer reduced by 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Operation code (0 none, 1 load, 2-6 save, 7-11 swap) |
| idx_i | input | 4 | Auxiliary entry index |
| fld_we_i | input | 1 | Pointer field write enable |
| fld_sel_i | input | 2 | Pointer field selected for write |
| fld_data_i | input | 4 | Field write data |
| step_i | input | 2 | Lowest-field step request (1 up, 2 down) |
| rd_sel_i | input | 2 | Field selected for the nibble read port |
| pc_o | output | 16 | Current pointer value |
| rd_nib_o | output | 4 | Selected pointer field |

## Verification
The assertions assume that every input is a known value in each cycle after reset. They also assume that a field select value names one of the four fields, which a 2-bit select always does. The bench drives every input through a known idle value between requests and never leaves a pin floating. It holds reset high from time zero, so no property sees the state that exists before the first edge. Operation codes 12 to 15 are applied on purpose, because the block must treat them as a no-operation.

// File: rtl/ptr_aux_pkg.sv
package ptr_aux_pkg;

    localparam int PC_W   = 16;
    localparam int NIB_W  = 4;
    localparam int NFLD   = PC_W / NIB_W;
    localparam int FSEL_W = $clog2(NFLD);

    typedef logic [PC_W-1:0]  word_t;
    typedef logic [NIB_W-1:0] nib_t;

    typedef enum logic [3:0] {
        OP_NONE  = 4'd0,
        OP_LOAD  = 4'd1,
        OP_SV_0  = 4'd2,
        OP_SV_P1 = 4'd3,
        OP_SV_M1 = 4'd4,
        OP_SV_P2 = 4'd5,
        OP_SV_M2 = 4'd6,
        OP_SW_0  = 4'd7,
        OP_SW_P1 = 4'd8,
        OP_SW_M1 = 4'd9,
        OP_SW_P2 = 4'd10,
        OP_SW_M2 = 4'd11
    } op_e;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2,
        STEP_IDLE = 2'd3
    } step_e;

    typedef struct packed {
        logic  pc_from_aux;
        logic  aux_from_pc;
        word_t delta;
    } dec_t;

    function automatic dec_t op_decode(logic [3:0] code);
        dec_t d;
        d = '{pc_from_aux: 1'b0, aux_from_pc: 1'b0, delta: '0};
        case (code)
            OP_LOAD:  d.pc_from_aux = 1'b1;
            OP_SV_0:  d.aux_from_pc = 1'b1;
            OP_SV_P1: begin d.aux_from_pc = 1'b1; d.delta = word_t'(1); end
            OP_SV_M1: begin d.aux_from_pc = 1'b1; d.delta = '1; end
            OP_SV_P2: begin d.aux_from_pc = 1'b1; d.delta = word_t'(2); end
            OP_SV_M2: begin d.aux_from_pc = 1'b1; d.delta = ~word_t'(1); end
            OP_SW_0:  begin d.pc_from_aux = 1'b1; d.aux_from_pc = 1'b1; end
            OP_SW_P1: begin d.pc_from_aux = 1'b1; d.aux_from_pc = 1'b1; d.delta = word_t'(1); end
            OP_SW_M1: begin d.pc_from_aux = 1'b1; d.aux_from_pc = 1'b1; d.delta = '1; end
            OP_SW_P2: begin d.pc_from_aux = 1'b1; d.aux_from_pc = 1'b1; d.delta = word_t'(2); end
            OP_SW_M2: begin d.pc_from_aux = 1'b1; d.aux_from_pc = 1'b1; d.delta = ~word_t'(1); end
            default:  ;
        endcase
        return d;
    endfunction

    function automatic nib_t field_next(nib_t cur, logic is_low, logic [1:0] step,
                                        logic hit, nib_t wdata);
        nib_t n;
        n = cur;
        if (is_low && step == STEP_UP)   n = cur + nib_t'(1);
        if (is_low && step == STEP_DOWN) n = cur - nib_t'(1);
        if (hit) n = wdata;
        return n;
    endfunction

endpackage

// File: rtl/paux_file.sv
module paux_file
    import ptr_aux_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  word_t            wdata,
    output word_t            rdata
);
    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[idx] <= wdata;
        end
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/paux_pcreg.sv
module paux_pcreg
    import ptr_aux_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  word_t             load_val,
    input  logic              fld_we,
    input  logic [FSEL_W-1:0] fld_sel,
    input  nib_t              fld_data,
    input  logic [1:0]        step,
    input  logic [FSEL_W-1:0] rd_sel,
    output word_t             pc,
    output nib_t              rd_nib
);
    word_t pc_q;
    word_t nib_path;

    for (genvar f = 0; f < NFLD; f++) begin : g_fld
        assign nib_path[f*NIB_W +: NIB_W] =
            field_next(pc_q[f*NIB_W +: NIB_W], (f == 0), step,
                       fld_we && (fld_sel == FSEL_W'(f)), fld_data);
    end

    always_ff @(posedge clk) begin
        if (rst)       pc_q <= '0;
        else if (load) pc_q <= load_val;
        else           pc_q <= nib_path;
    end

    assign pc     = pc_q;
    assign rd_nib = pc_q[rd_sel*NIB_W +: NIB_W];
endmodule

// File: rtl/ptr_aux_unit.sv
module ptr_aux_unit
    import ptr_aux_pkg::*;
#(
    parameter int AUX_DEPTH = 16,
    localparam int IDX_W = $clog2(AUX_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              fld_we_i,
    input  logic [FSEL_W-1:0] fld_sel_i,
    input  logic [NIB_W-1:0]  fld_data_i,
    input  logic [1:0]        step_i,
    input  logic [FSEL_W-1:0] rd_sel_i,
    output logic [PC_W-1:0]   pc_o,
    output logic [NIB_W-1:0]  rd_nib_o
);
    dec_t  dec;
    word_t aux_rd;
    word_t pc_cur;
    word_t aux_wdata;

    assign dec       = op_decode(op_i);
    assign aux_wdata = pc_cur + dec.delta;

    paux_file #(.DEPTH(AUX_DEPTH)) u_file (
        .clk   (clk),
        .rst   (rst),
        .we    (dec.aux_from_pc),
        .idx   (idx_i),
        .wdata (aux_wdata),
        .rdata (aux_rd)
    );

    paux_pcreg u_pc (
        .clk      (clk),
        .rst      (rst),
        .load     (dec.pc_from_aux),
        .load_val (aux_rd),
        .fld_we   (fld_we_i),
        .fld_sel  (fld_sel_i),
        .fld_data (fld_data_i),
        .step     (step_i),
        .rd_sel   (rd_sel_i),
        .pc       (pc_cur),
        .rd_nib   (rd_nib_o)
    );

    assign pc_o = pc_cur;
endmodule

// File: rtl/ptr_aux_chk.sv
module ptr_aux_chk
    import ptr_aux_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [3:0]        op_i,
    input logic              fld_we_i,
    input logic [FSEL_W-1:0] fld_sel_i,
    input logic [NIB_W-1:0]  fld_data_i,
    input logic [1:0]        step_i,
    input logic [PC_W-1:0]   pc_o,
    input logic [PC_W-1:0]   aux_rd
);
    function automatic nib_t pick(word_t w, logic [FSEL_W-1:0] s);
        return w[s*NIB_W +: NIB_W];
    endfunction

    logic is_load, is_swap, is_save, quiet, stepping;
    assign is_load  = (op_i == OP_LOAD);
    assign is_swap  = (op_i >= OP_SW_0) && (op_i <= OP_SW_M2);
    assign is_save  = (op_i >= OP_SV_0) && (op_i <= OP_SV_M2);
    assign stepping = (step_i == STEP_UP) || (step_i == STEP_DOWN);
    assign quiet    = !is_load && !is_swap;

    p_load_takes_aux_r2: assert property (@(posedge clk) disable iff (rst)
        is_load |=> pc_o == $past(aux_rd));

    p_save_holds_pc_r3: assert property (@(posedge clk) disable iff (rst)
        (is_save && !fld_we_i && !stepping) |=> pc_o == $past(pc_o));

    p_swap_takes_aux_r4: assert property (@(posedge clk) disable iff (rst)
        is_swap |=> pc_o == $past(aux_rd));

    p_field_write_r6: assert property (@(posedge clk) disable iff (rst)
        (quiet && fld_we_i) |=> pick(pc_o, $past(fld_sel_i)) == $past(fld_data_i));

    p_no_carry_r7: assert property (@(posedge clk) disable iff (rst)
        (quiet && !fld_we_i && stepping) |=> pc_o[PC_W-1:NIB_W] == $past(pc_o[PC_W-1:NIB_W]));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (quiet && !is_save && !fld_we_i && !stepping) |=> $stable(pc_o));
endmodule

bind ptr_aux_unit ptr_aux_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_i       (op_i),
    .fld_we_i   (fld_we_i),
    .fld_sel_i  (fld_sel_i),
    .fld_data_i (fld_data_i),
    .step_i     (step_i),
    .pc_o       (pc_o),
    .aux_rd     (aux_rd)
);

// File: tb/test_ptr_aux_unit.sv
`timescale 1ns/1ps
module test_ptr_aux_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_i = '0;
    logic [3:0]  idx_i = '0;
    logic        fld_we_i = 1'b0;
    logic [1:0]  fld_sel_i = '0;
    logic [3:0]  fld_data_i = '0;
    logic [1:0]  step_i = '0;
    logic [1:0]  rd_sel_i = '0;
    logic [15:0] pc_o;
    logic [3:0]  rd_nib_o;

    always #4 clk = ~clk;

    ptr_aux_unit i_ptr_aux_unit (
        .clk(clk), .rst(rst), .op_i(op_i), .idx_i(idx_i),
        .fld_we_i(fld_we_i), .fld_sel_i(fld_sel_i), .fld_data_i(fld_data_i),
        .step_i(step_i), .rd_sel_i(rd_sel_i), .pc_o(pc_o), .rd_nib_o(rd_nib_o)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic [3:0]  op;
        logic [3:0]  idx;
        logic        fwe;
        logic [1:0]  fsel;
        logic [3:0]  fdat;
        logic [1:0]  step;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 36;
    localparam vec_t VECS [NV] = '{
        '{8'd1,  4'd1,  4'd15, 1'b0, 2'd0, 4'h0, 2'd0, 16'h0000}, // R1 cleared entry
        '{8'd6,  4'd0,  4'd0,  1'b1, 2'd0, 4'h5, 2'd0, 16'h0005}, // R6
        '{8'd6,  4'd0,  4'd0,  1'b1, 2'd1, 4'hA, 2'd0, 16'h00A5},
        '{8'd6,  4'd0,  4'd0,  1'b1, 2'd2, 4'h3, 2'd0, 16'h03A5},
        '{8'd6,  4'd0,  4'd0,  1'b1, 2'd3, 4'hC, 2'd0, 16'hC3A5},
        '{8'd3,  4'd5,  4'd3,  1'b0, 2'd0, 4'h0, 2'd0, 16'hC3A5}, // R3 save +2
        '{8'd7,  4'd0,  4'd0,  1'b0, 2'd0, 4'h0, 2'd1, 16'hC3A6}, // R7 up
        '{8'd2,  4'd1,  4'd3,  1'b0, 2'd0, 4'h0, 2'd0, 16'hC3A7}, // R2 load
        '{8'd6,  4'd0,  4'd0,  1'b1, 2'd0, 4'hF, 2'd0, 16'hC3AF},
        '{8'd7,  4'd0,  4'd0,  1'b0, 2'd0, 4'h0, 2'd1, 16'hC3A0}, // R7 wrap up
        '{8'd7,  4'd0,  4'd0,  1'b0, 2'd0, 4'h0, 2'd2, 16'hC3AF}, // R7 wrap down
        '{8'd8,  4'd0,  4'd0,  1'b1, 2'd0, 4'h0, 2'd1, 16'hC3A0}, // R8 write wins
        '{8'd7,  4'd0,  4'd0,  1'b0, 2'd0, 4'h0, 2'd2, 16'hC3AF},
        '{8'd8,  4'd0,  4'd0,  1'b1, 2'd2, 4'h7, 2'd1, 16'hC7A0}, // R8 both apply
        '{8'd4,  4'd9,  4'd5,  1'b0, 2'd0, 4'h0, 2'd0, 16'h0000}, // R4 swap -1
        '{8'd4,  4'd1,  4'd5,  1'b0, 2'd0, 4'h0, 2'd0, 16'hC79F},
        '{8'd4,  4'd8,  4'd5,  1'b0, 2'd0, 4'h0, 2'd0, 16'hC79F}, // R4 swap +1
        '{8'd4,  4'd1,  4'd5,  1'b0, 2'd0, 4'h0, 2'd0, 16'hC7A0},
        '{8'd3,  4'd6,  4'd7,  1'b0, 2'd0, 4'h0, 2'd0, 16'hC7A0}, // R3 save -2
        '{8'd4,  4'd7,  4'd7,  1'b0, 2'd0, 4'h0, 2'd0, 16'hC79E}, // R4 plain swap
        '{8'd4,  4'd1,  4'd7,  1'b0, 2'd0, 4'h0, 2'd0, 16'hC7A0},
        '{8'd2,  4'd1,  4'd0,  1'b0, 2'd0, 4'h0, 2'd0, 16'h0000},
        '{8'd5,  4'd4,  4'd9,  1'b0, 2'd0, 4'h0, 2'd0, 16'h0000}, // R5 save -1 of 0
        '{8'd5,  4'd1,  4'd9,  1'b0, 2'd0, 4'h0, 2'd0, 16'hFFFF},
        '{8'd5,  4'd3,  4'd10, 1'b0, 2'd0, 4'h0, 2'd0, 16'hFFFF}, // R5 save +1 of FFFF
        '{8'd5,  4'd1,  4'd10, 1'b0, 2'd0, 4'h0, 2'd0, 16'h0000},
        '{8'd5,  4'd1,  4'd9,  1'b0, 2'd0, 4'h0, 2'd0, 16'hFFFF},
        '{8'd5,  4'd5,  4'd11, 1'b0, 2'd0, 4'h0, 2'd0, 16'hFFFF},
        '{8'd5,  4'd1,  4'd11, 1'b0, 2'd0, 4'h0, 2'd0, 16'h0001},
        '{8'd10, 4'd0,  4'd9,  1'b0, 2'd0, 4'h0, 2'd0, 16'h0001}, // R10
        '{8'd10, 4'd13, 4'd9,  1'b0, 2'd0, 4'h0, 2'd0, 16'h0001},
        '{8'd10, 4'd1,  4'd9,  1'b0, 2'd0, 4'h0, 2'd0, 16'hFFFF}, // entry 9 untouched
        '{8'd9,  4'd1,  4'd3,  1'b1, 2'd3, 4'h0, 2'd1, 16'hC3A7}, // R9 load wins
        '{8'd12, 4'd11, 4'd3,  1'b0, 2'd0, 4'h0, 2'd0, 16'hC3A7}, // R12
        '{8'd12, 4'd7,  4'd3,  1'b0, 2'd0, 4'h0, 2'd0, 16'hC3A5},
        '{8'd12, 4'd1,  4'd3,  1'b0, 2'd0, 4'h0, 2'd0, 16'hC3A7}
    };

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic check(input logic [15:0] act, input logic [15:0] exp,
                         input int req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        op_i = '0; idx_i = '0; fld_we_i = 1'b0; fld_sel_i = '0;
        fld_data_i = '0; step_i = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(pc_o, 16'h0000, 1, "pointer after reset");
        rst = 1'b0;
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            op_i = VECS[v].op; idx_i = VECS[v].idx; fld_we_i = VECS[v].fwe;
            fld_sel_i = VECS[v].fsel; fld_data_i = VECS[v].fdat; step_i = VECS[v].step;
            @(posedge clk);
            #1 idle();
            @(negedge clk);
            check(pc_o, VECS[v].exp, int'(VECS[v].req), $sformatf("vector %0d", v));
        end
        // R11: nibble read port, pointer is C3A7
        for (int s = 0; s < 4; s++) begin
            rd_sel_i = 2'(s);
            #1;
            check({12'h0, rd_nib_o}, {12'h0, 4'(16'hC3A7 >> (4 * s))}, 11, "nibble read");
        end
        // R1: reset mid-run clears pointer and entries
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk);
        check(pc_o, 16'h0000, 1, "pointer after second reset");
        rst = 1'b0;
        op_i = 4'd1; idx_i = 4'd3;
        @(posedge clk); #1 idle();
        @(negedge clk);
        check(pc_o, 16'h0000, 1, "entry 3 after second reset");
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule